// File: doc/BRIEF.md
# External Reset Pulse Generator

This block turns a single-cycle expiry pulse from a watchdog into a timed pulse on an external reset pin. The pulse length is counted in ticks of a 1 MHz strobe. The block lasts one tick longer than the programmed width value, so a width of zero still gives a one-microsecond pulse. The pin is modelled as a data level plus an output-enable. Together these two signals give either push-pull drive or open-drain drive, with either polarity.

One 32-bit configuration word sets the width, the polarity and the drive mode. The width field is rewritten on every write. Polarity and drive mode change only when the top byte of the written data holds one of four key values. Any other top byte leaves them as they were. Both mode bits read back directly.

The sequencer has two states:
- `XS_IDLE`: the pin sits at its inactive level.
- `XS_ACTIVE`: the pin is driven to the active level.

It has three transitions:
- START (`XS_IDLE`→`XS_ACTIVE`): taken on a trigger while the external-signal enable is high. The width value is captured into the down-counter at this point.
- COUNT (`XS_ACTIVE`→`XS_ACTIVE`): taken on each tick while the counter is non-zero. The counter decrements.
- EXPIRE (`XS_ACTIVE`→`XS_IDLE`): taken on a tick when the counter is zero.

Top module: `ext_rst_pulse_gen`

## Requirements
- R1: After reset the configuration reads 0x000000FF (width 255, active-low, open-drain), `pin_out` is 1 and `pin_oe` is 0.
- R2: Every register write loads bits 19:0 of the written data into the width field. Read data bits 29:20 are always 0.
- R3: A write whose top byte is 0xA5 sets read bit 31 (active-high). A write whose top byte is 0x5A clears it (active-low).
- R4: A write whose top byte is 0xA8 sets read bit 30 (push-pull). A write whose top byte is 0x8A clears it (open-drain).
- R5: A write with any other top-byte value leaves read bits 31 and 30 unchanged.
- R6: A trigger seen in idle while `ext_en` is 1 starts a pulse on the next cycle. The pulse ends after it has seen exactly width+1 ticks.
- R7: A trigger while `ext_en` is 0 produces no pulse.
- R8: A trigger during a pulse is ignored. A width write during a pulse does not change that pulse's length, because the width is sampled at the trigger.
- R9: `pin_out` equals bit 31 while a pulse is active and its inverse otherwise.
- R10: In push-pull mode `pin_oe` is always 1. In open-drain mode `pin_oe` is 1 only while a pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle strobe per microsecond |
| trigger | input | 1 | One-cycle watchdog expiry pulse |
| ext_en | input | 1 | External-signal enable from watchdog control |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| pin_out | output | 1 | Pin data level |
| pin_oe | output | 1 | Pin output-enable |

## Verification
Pulses are fired at widths 0, 2, 3, 5 and 255, under three polarity and drive combinations. The widths distinguish an off-by-one in the tick count. The mode combinations separate the level logic from the enable logic.

A retrigger in mid-pulse and a width rewrite in mid-pulse each show whether the counter is reloaded. A trigger with the enable low shows whether the enable gates the start.

Writes with each key byte and with a non-key byte show whether the mode bits and the width field are updated independently.

// File: rtl/xrst_pkg.sv
package xrst_pkg;
    typedef enum logic {
        XS_IDLE   = 1'b0,
        XS_ACTIVE = 1'b1
    } xrst_state_e;

    localparam logic [7:0] KEY_POL_HI = 8'hA5;
    localparam logic [7:0] KEY_POL_LO = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD = 8'h8A;
endpackage

// File: rtl/xrst_cfg.sv
module xrst_cfg
    import xrst_pkg::*;
#(
    parameter int WIDTH_W   = 20,
    parameter int RST_WIDTH = 255
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wdata,
    output logic [WIDTH_W-1:0] width_o,
    output logic               pol_hi_o,
    output logic               push_pull_o,
    output logic [31:0]        rdata_o
);
    logic [7:0] key;
    assign key = wdata[31:24];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_o     <= WIDTH_W'(RST_WIDTH);
            pol_hi_o    <= 1'b0;
            push_pull_o <= 1'b0;
        end else if (wr_en) begin
            width_o <= wdata[WIDTH_W-1:0];
            unique case (key)
                KEY_POL_HI: pol_hi_o    <= 1'b1;
                KEY_POL_LO: pol_hi_o    <= 1'b0;
                KEY_DRV_PP: push_pull_o <= 1'b1;
                KEY_DRV_OD: push_pull_o <= 1'b0;
                default:    ;
            endcase
        end
    end

    always_comb begin
        rdata_o                = '0;
        rdata_o[WIDTH_W-1:0]   = width_o;
        rdata_o[31]            = pol_hi_o;
        rdata_o[30]            = push_pull_o;
    end

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key != KEY_POL_HI && key != KEY_POL_LO &&
         key != KEY_DRV_PP && key != KEY_DRV_OD)
        |=> ($stable(pol_hi_o) && $stable(push_pull_o)));

    // R3
    pol_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key == KEY_POL_HI) |=> pol_hi_o);

    // R4
    drv_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key == KEY_DRV_OD) |=> !push_pull_o);
endmodule

// File: rtl/xrst_fsm.sv
module xrst_fsm
    import xrst_pkg::*;
#(
    parameter int WIDTH_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               trigger,
    input  logic               enable,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               active_o
);
    xrst_state_e        state_q, state_d;
    logic [WIDTH_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            XS_IDLE: begin
                if (trigger && enable) begin
                    state_d = XS_ACTIVE;
                    cnt_d   = width_i;
                end
            end
            XS_ACTIVE: begin
                if (tick) begin
                    if (cnt_q == '0) state_d = XS_IDLE;
                    else             cnt_d   = cnt_q - 1'b1;
                end
            end
            default: state_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        active_o = (state_q == XS_ACTIVE);
    end

    // R6
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && trigger && enable) |=> active_o);

    // R7
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !(trigger && enable)) |=> !active_o);

    // R8
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !tick) |=> (active_o && $stable(cnt_q)));

    // R6
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && tick && cnt_q != '0) |=> (active_o && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/xrst_pad.sv
module xrst_pad (
    input  logic active_i,
    input  logic pol_hi_i,
    input  logic push_pull_i,
    output logic pin_o,
    output logic oe_o
);
    always_comb begin
        pin_o = active_i ? pol_hi_i : ~pol_hi_i;
        oe_o  = push_pull_i | active_i;
    end
endmodule

// File: rtl/ext_rst_pulse_gen.sv
module ext_rst_pulse_gen #(
    parameter int WIDTH_W   = 20,
    parameter int RST_WIDTH = 255
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1us,
    input  logic        trigger,
    input  logic        ext_en,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        pin_out,
    output logic        pin_oe
);
    logic [WIDTH_W-1:0] width;
    logic               pol_hi;
    logic               push_pull;
    logic               pulse_active;

    xrst_cfg #(.WIDTH_W(WIDTH_W), .RST_WIDTH(RST_WIDTH)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
        .width_o(width), .pol_hi_o(pol_hi), .push_pull_o(push_pull),
        .rdata_o(cfg_rdata)
    );

    xrst_fsm #(.WIDTH_W(WIDTH_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_1us), .trigger(trigger),
        .enable(ext_en), .width_i(width), .active_o(pulse_active)
    );

    xrst_pad pad_i (
        .active_i(pulse_active), .pol_hi_i(pol_hi), .push_pull_i(push_pull),
        .pin_o(pin_out), .oe_o(pin_oe)
    );

    // R10
    pp_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[30] |-> pin_oe);

    // R10
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[30] && !pulse_active) |-> !pin_oe);

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_active |-> (pin_out != cfg_rdata[31]));
endmodule

// File: tb/ext_rst_pulse_gen_tb_top.sv
module ext_rst_pulse_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        trigger = 1'b0;
    logic        ext_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pin_out;
    logic        pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    int pulses_seen = 0;
    logic exp_pol = 1'b0;

    typedef struct { int ticks; logic lvl; string req; } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    ext_rst_pulse_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .trigger(trigger),
        .ext_en(ext_en), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // tick generator: one strobe every 4 cycles
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #1;
            tick_1us = (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    // monitor: measure each pulse and compare with the scoreboard
    initial begin
        logic prev_act = 1'b0;
        int   ticks = 0;
        logic oe_ok = 1'b1;
        logic lvl = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                logic act;
                act = (pin_out === exp_pol);
                if (act) begin
                    if (!prev_act) begin ticks = 0; oe_ok = 1'b1; lvl = pin_out; end
                    if (tick_1us) ticks++;
                    if (pin_oe !== 1'b1) oe_ok = 1'b0;
                end else if (prev_act) begin
                    pulses_seen++;
                    if (sb_q.size() == 0) begin
                        check("R7 unexpected pulse", 32'd1, 32'd0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check({e.req, " R6 tick count"}, ticks, e.ticks);
                        check("R9 active level", {31'd0, lvl}, {31'd0, e.lvl});
                        check("R10 oe during pulse", {31'd0, oe_ok}, 32'd1);
                    end
                end
                prev_act = act;
            end
        end
    end

    task automatic cfg_write(logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        if (d[31:24] == 8'hA5) exp_pol = 1'b1;
        if (d[31:24] == 8'h5A) exp_pol = 1'b0;
    endtask

    task automatic fire(logic en, int exp_ticks, string req);
        exp_t e;
        @(posedge clk); #1;
        trigger = 1'b1; ext_en = en;
        if (en) begin
            e.ticks = exp_ticks; e.lvl = exp_pol; e.req = req;
            sb_q.push_back(e);
        end
        @(posedge clk); #1;
        trigger = 1'b0;
    endtask

    task automatic wait_pulses(int n);
        while (pulses_seen < n) @(negedge clk);
    endtask

    task automatic read_chk(string req, logic [31:0] exp);
        @(negedge clk);
        check(req, cfg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        read_chk("R1 reset readback", 32'h0000_00FF);
        check("R1 idle pin level", {31'd0, pin_out}, 32'd1);
        check("R1 idle oe", {31'd0, pin_oe}, 32'd0);

        // R6 default width 255 -> 256 ticks, active-low open-drain
        fire(1'b1, 256, "R1");
        wait_pulses(1);
        @(negedge clk);
        check("R10 oe released after pulse", {31'd0, pin_oe}, 32'd0);

        // R2/R5 plain width write
        cfg_write(32'h0000_0003);
        read_chk("R2 R5 width write", 32'h0000_0003);

        // R8 retrigger during a pulse is ignored
        fire(1'b1, 4, "R8 retrigger");
        repeat (3) @(posedge clk);
        fire(1'b1, 0, "unused");
        void'(sb_q.pop_back());
        wait_pulses(2);

        // R8 width rewrite during pulse does not alter it
        fire(1'b1, 4, "R8 width rewrite");
        repeat (2) @(posedge clk);
        cfg_write(32'h0000_0009);
        wait_pulses(3);
        read_chk("R2 mid-pulse write kept", 32'h0000_0009);

        // R7 disabled trigger
        fire(1'b0, 0, "R7");
        repeat (60) @(posedge clk);
        @(negedge clk);
        check("R7 no pulse count", pulses_seen, 3);
        check("R7 pin stays idle", {31'd0, pin_out}, 32'd1);

        // R3 active-high, width 0 -> 1 tick
        cfg_write(32'hA500_0000);
        read_chk("R3 set active-high", 32'h8000_0000);
        check("R9 idle level inverted", {31'd0, pin_out}, 32'd0);
        fire(1'b1, 1, "R3 width zero");
        wait_pulses(4);

        // R4 push-pull, width 5
        cfg_write(32'hA800_0005);
        read_chk("R4 set push-pull", 32'hC000_0005);
        check("R10 push-pull idle oe", {31'd0, pin_oe}, 32'd1);
        fire(1'b1, 6, "R4 push-pull");
        wait_pulses(5);
        @(negedge clk);
        check("R10 push-pull oe after pulse", {31'd0, pin_oe}, 32'd1);

        // R5 non-key top byte, full width field
        cfg_write(32'h3C0F_FFFF);
        read_chk("R5 R2 non-key write", 32'hC00F_FFFF);

        // R3/R4 back to active-low open-drain
        cfg_write(32'h5A00_0002);
        read_chk("R3 clear active-high", 32'h4000_0002);
        cfg_write(32'h8A00_0002);
        read_chk("R4 clear push-pull", 32'h0000_0002);
        check("R10 open-drain idle oe", {31'd0, pin_oe}, 32'd0);
        fire(1'b1, 3, "R6 width two");
        wait_pulses(6);
        repeat (20) @(posedge clk);
        check("R6 scoreboard drained", sb_q.size(), 0);
        finish_run();
    end
endmodule